// File: doc/BRIEF.md
# Binary to two-digit seven-segment decoder

This block converts a 4-bit unsigned value into the segment drive for a two-digit decimal seven-segment display. Every value from 0 to 15 appears as two decimal digits, and values below ten keep a leading zero. The block has no clock and no state. Its outputs follow the input through combinational logic only.

The segment lines do not go out one digit per bus. They are split by height on the display. One bus carries the segments in the upper half of both digits. The other bus carries the lower segments and the decimal points of both digits. The decimal points are tied dark. All segments are active high: a 1 lights the segment.

Top module: `seg2_decoder`

## Requirements
- R1: The tens digit shows 1 when the input is 10 or more and shows 0 otherwise. The zero is always drawn and never blanked.
- R2: The units digit shows the input minus 10 when the input is 10 or more, and shows the input itself otherwise.
- R3: The top bus carries tens segments a, b, f, g in bits 7, 6, 5, 4 and units segments a, b, f, g in bits 3, 2, 1, 0.
- R4: The bottom bus carries tens segments c, d, e in bits 7, 6, 5 and units segments c, d, e in bits 3, 2, 1. Bits 4 and 0 are the decimal points and are 0 for every input.
- R5: Digit patterns, given as the lit segments (active high): 0 = abcdef, 1 = bc, 2 = abdeg, 3 = abcdg, 4 = bcfg, 5 = acdfg, 6 = acdefg, 7 = abc, 8 = abcdefg, 9 = abcdfg.
- R6: The outputs settle on a new input value within the same clock phase. No clock edge is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| value_i | input | 4 | Unsigned value to display, 0 to 15 |
| seg_top_o | output | 8 | Upper segments a, b, f, g: tens in bits 7..4, units in bits 3..0 |
| seg_bot_o | output | 8 | Lower segments c, d, e and the decimal point: tens in bits 7..4, units in bits 3..0 |

## Verification
The hardest case to reach from the ports is the 9 to 10 boundary. Here both digits change at once, the tens digit leaves its leading zero and the units digit wraps back to zero. It is easy to hit this edge only in one direction. The stimulus therefore walks all sixteen inputs in order and then in reverse, and it also jumps across the boundary both ways within one clock phase. Because the outputs are checked a short delay after each change, a stale or registered output would be caught.

// File: rtl/seg2_pkg.sv
package seg2_pkg;
  localparam int unsigned DIG_W = 4;
  localparam int unsigned BUS_W = 8;

  typedef struct packed {
    logic a;
    logic b;
    logic c;
    logic d;
    logic e;
    logic f;
    logic g;
  } seg7_t;
endpackage

// File: rtl/seg2_bin_split.sv
module seg2_bin_split #(
  parameter int unsigned VAL_W = 4,
  parameter int unsigned RADIX = 10
) (
  input  logic [VAL_W-1:0]            value_i,
  output logic [seg2_pkg::DIG_W-1:0]  tens_o,
  output logic [seg2_pkg::DIG_W-1:0]  units_o
);
  import seg2_pkg::*;
  localparam logic [VAL_W-1:0] RADIX_V = VAL_W'(RADIX);

  logic             over;
  logic [VAL_W-1:0] rem;

  // Range tops out below 2*RADIX, so one compare-subtract stage is enough.
  always_comb begin
    over    = (value_i >= RADIX_V);
    rem     = over ? (value_i - RADIX_V) : value_i;
    tens_o  = over ? DIG_W'(1) : '0;
    units_o = DIG_W'(rem);
  end
endmodule

// File: rtl/seg2_digit_enc.sv
module seg2_digit_enc (
  input  logic [seg2_pkg::DIG_W-1:0] digit_i,
  output seg2_pkg::seg7_t            seg_o
);
  import seg2_pkg::*;

  always_comb begin
    unique case (digit_i)
      4'd0:    seg_o = 7'b1111110;
      4'd1:    seg_o = 7'b0110000;
      4'd2:    seg_o = 7'b1101101;
      4'd3:    seg_o = 7'b1111001;
      4'd4:    seg_o = 7'b0110011;
      4'd5:    seg_o = 7'b1011011;
      4'd6:    seg_o = 7'b1011111;
      4'd7:    seg_o = 7'b1110000;
      4'd8:    seg_o = 7'b1111111;
      4'd9:    seg_o = 7'b1111011;
      default: seg_o = '0;
    endcase
  end
endmodule

// File: rtl/seg2_bus_pack.sv
module seg2_bus_pack #(
  parameter int unsigned DIGITS = 2
) (
  input  seg2_pkg::seg7_t          seg_i [DIGITS],
  output logic [4*DIGITS-1:0]      top_o,
  output logic [4*DIGITS-1:0]      bot_o
);
  import seg2_pkg::*;

  // Digit 0 is units (low nibble), digit DIGITS-1 is the leftmost.
  for (genvar k = 0; k < DIGITS; k++) begin : g_dig
    assign top_o[4*k +: 4] = {seg_i[k].a, seg_i[k].b, seg_i[k].f, seg_i[k].g};
    assign bot_o[4*k +: 4] = {seg_i[k].c, seg_i[k].d, seg_i[k].e, 1'b0};
  end
endmodule

// File: rtl/seg2_decoder.sv
module seg2_decoder #(
  parameter int unsigned VAL_W = 4
) (
  input  logic [VAL_W-1:0]            value_i,
  output logic [seg2_pkg::BUS_W-1:0]  seg_top_o,
  output logic [seg2_pkg::BUS_W-1:0]  seg_bot_o
);
  import seg2_pkg::*;
  localparam int unsigned DIGITS = BUS_W / 4;

  logic [DIG_W-1:0] digit [DIGITS];
  seg7_t            seg   [DIGITS];

  seg2_bin_split #(.VAL_W(VAL_W), .RADIX(10)) u_split (
    .value_i (value_i),
    .tens_o  (digit[1]),
    .units_o (digit[0])
  );

  for (genvar k = 0; k < DIGITS; k++) begin : g_enc
    seg2_digit_enc u_enc (
      .digit_i (digit[k]),
      .seg_o   (seg[k])
    );
  end

  seg2_bus_pack #(.DIGITS(DIGITS)) u_pack (
    .seg_i (seg),
    .top_o (seg_top_o),
    .bot_o (seg_bot_o)
  );
endmodule

// File: rtl/seg2_decoder_chk.sv
module seg2_decoder_chk (
  input logic [3:0] value_i,
  input logic [7:0] seg_top_o,
  input logic [7:0] seg_bot_o
);
  always_comb begin
    if (!$isunknown(value_i)) begin
      p_dp_dark_r4: assert (seg_bot_o[4] == 1'b0 && seg_bot_o[0] == 1'b0);
      // R1: the tens digit is either a drawn 0 or a 1
      if (value_i >= 4'd10) begin
        p_tens_one_r1: assert (seg_top_o[7:4] == 4'b0100 && seg_bot_o[7:5] == 3'b100);
      end else begin
        p_tens_zero_r1: assert (seg_top_o[7:4] == 4'b1110 && seg_bot_o[7:5] == 3'b111);
      end
      // R2: the units digit wraps to 0 at ten
      if (value_i == 4'd0 || value_i == 4'd10) begin
        p_units_wrap_r2: assert (seg_top_o[3:0] == 4'b1110 && seg_bot_o[3:1] == 3'b111);
      end
      // R5: eight lights all seven units segments
      if (value_i == 4'd8) begin
        p_eight_full_r5: assert ($countones({seg_top_o[3:0], seg_bot_o[3:1]}) == 7);
      end
    end
  end
endmodule

bind seg2_decoder seg2_decoder_chk u_chk (
  .value_i   (value_i),
  .seg_top_o (seg_top_o),
  .seg_bot_o (seg_bot_o)
);

// File: tb/seg2_decoder_tb_top.sv
module seg2_decoder_tb_top;
  localparam int unsigned CLK_PERIOD = 10;

  logic       clk;
  logic [3:0] value_i;
  logic [7:0] seg_top_o;
  logic [7:0] seg_bot_o;
  int         n_total = 0;
  int         n_bad   = 0;
  bit         ended   = 0;

  seg2_decoder dut_i (
    .value_i   (value_i),
    .seg_top_o (seg_top_o),
    .seg_bot_o (seg_bot_o)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Segment sets per digit from R5, as {a,b,c,d,e,f,g}.
  function automatic logic [6:0] pat(input int d);
    case (d)
      0: pat = 7'b1111110;
      1: pat = 7'b0110000;
      2: pat = 7'b1101101;
      3: pat = 7'b1111001;
      4: pat = 7'b0110011;
      5: pat = 7'b1011011;
      6: pat = 7'b1011111;
      7: pat = 7'b1110000;
      8: pat = 7'b1111111;
      9: pat = 7'b1111011;
      default: pat = 7'b0;
    endcase
  endfunction

  // R3/R4 placement of one digit's segments into its nibbles.
  function automatic logic [3:0] top_nib(input logic [6:0] p);
    top_nib = {p[6], p[5], p[1], p[0]};
  endfunction
  function automatic logic [3:0] bot_nib(input logic [6:0] p);
    bot_nib = {p[4], p[3], p[2], 1'b0};
  endfunction

  function automatic logic [15:0] expect_of(input int v);
    int t, u;
    t = (v >= 10) ? 1 : 0;
    u = (v >= 10) ? v - 10 : v;
    expect_of = {top_nib(pat(t)), top_nib(pat(u)), bot_nib(pat(t)), bot_nib(pat(u))};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_total++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s value=%0d act=%h exp=%h", req, value_i, act, exp);
    end
  endtask

  task automatic apply_check(input int v, input string req);
    value_i = 4'(v);
    #1;
    check(req, {seg_top_o, seg_bot_o}, expect_of(v));
  endtask

  // R1 R2 R3 R5: full sweep upward
  task automatic t_sweep_up();
    for (int v = 0; v < 16; v++) begin
      @(negedge clk);
      apply_check(v, "R1/R2/R3/R5 up");
    end
  endtask

  // R1 R2: sweep downward
  task automatic t_sweep_down();
    for (int v = 15; v >= 0; v--) begin
      @(negedge clk);
      apply_check(v, "R1/R2 down");
    end
  endtask

  // R4: decimal points dark for every input
  task automatic t_dp_dark();
    for (int v = 0; v < 16; v++) begin
      @(negedge clk);
      value_i = 4'(v);
      #1;
      check("R4 dp", {14'b0, seg_bot_o[4], seg_bot_o[0]}, 16'h0);
    end
  endtask

  // R6: several changes within one clock phase, no edge between
  task automatic t_no_clock();
    @(negedge clk);
    apply_check(9, "R6 9");
    apply_check(10, "R6 10");
    apply_check(9, "R6 back 9");
    apply_check(15, "R6 15");
    apply_check(0, "R6 0");
  endtask

  // Fixed literal spot checks of the packed buses (R1 R3 R4 R5)
  task automatic t_literals();
    @(negedge clk);
    value_i = 4'd0;  #1; check("R1 literal 00", {seg_top_o, seg_bot_o}, 16'hEEEE);
    value_i = 4'd7;  #1; check("R5 literal 07", {seg_top_o, seg_bot_o}, 16'hECE8);
    value_i = 4'd12; #1; check("R3 literal 12", {seg_top_o, seg_bot_o}, 16'h4D86);
    value_i = 4'd15; #1; check("R4 literal 15", {seg_top_o, seg_bot_o}, 16'h4B8C);
  endtask

  initial begin
    #(CLK_PERIOD * 2000);
    if (!ended) begin
      n_total++;
      n_bad++;
      $display("FAIL watchdog expired act=running exp=done");
      ended = 1;
      $display("test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
    end
  end

  initial begin
    value_i = 4'd0;
    @(negedge clk);
    #1;
    check("R1 initial", {seg_top_o, seg_bot_o}, expect_of(0));
    t_sweep_up();
    t_sweep_down();
    t_dp_dark();
    t_no_clock();
    t_literals();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
    end
  end
endmodule